// File: doc/BRIEF.md
# Auto-Indexing Pointer Memory Unit

This unit carries out the register-indirect memory operations of a small 16-bit processor. At launch it receives an operation code, the current value of a pointer register and the current accumulator. It then walks a byte-wide memory through a request/ready port, one byte per accepted access. When the last byte is accepted it returns three things for one cycle: the new pointer value, the new accumulator value (for loads), and the zero/negative/carry flag values.

Each operation moves its pointer in a fixed way. Loads and stores that walk upward use the pointer first and then add the byte count. Pop and push-style operations walk downward: they subtract first and then access. Word transfers are split into two byte accesses in a fixed order. The low byte sits at the lower address. Upward word transfers touch the low byte first. The downward word pop touches the high byte first. Instruction fetch, the register file and arithmetic belong to neighbouring blocks.

Top module: `ptr_mem_unit`

## Requirements
- R1: After reset, busy, done, mem_req, acc_we and all three flags are 0, and acc_out and ptr_out are 0.
- R2: Operation code 0 (byte load) reads address P, where P is the launch pointer. It returns {8'h00, byte} on acc_out with acc_we=1 and P+1 on ptr_out.
- R3: Code 1 (byte store) writes the low byte of the launch accumulator to address P and returns P+1. acc_we stays 0.
- R4: Code 2 (word load) reads P and then P+1, in that order. It returns {byte(P+1), byte(P)} and P+2.
- R5: Code 3 (word store) writes accumulator bits 7:0 to P and then bits 15:8 to P+1, in that order. It returns P+2 with acc_we=0.
- R6: Code 4 (byte pop) reads address P-1 and returns {8'h00, byte} with P-1. The result therefore always has N=0.
- R7: Code 5 (decrementing byte store) writes the accumulator's low byte to P-1 and returns P-1 with acc_we=0.
- R8: Code 6 (word pop) reads P-1 as the high byte and then P-2 as the low byte. It returns the assembled word and P-2.
- R9: At done, flag_c=0. flag_z and flag_n reflect the transferred value as a 16-bit quantity (byte transfers are zero-extended): flag_z is 1 when it is zero, and flag_n equals its bit 15.
- R10: All pointer and address arithmetic wraps modulo 2^16.
- R11: busy rises in the cycle after an accepted launch and falls in the cycle after the last byte access completes. done is a one-cycle pulse in that same cycle and is never high together with busy.
- R12: While mem_req is high and mem_ready is low, mem_addr, mem_we and mem_wdata hold their values.
- R13: A launch while busy is ignored, and so is code 7. Neither produces a memory access or a done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch request, sampled while not busy |
| op | input | 3 | Operation code (see requirements) |
| ptr_in | input | 16 | Pointer register value at launch |
| acc_in | input | 16 | Accumulator value at launch |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse with results |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid with mem_ready |
| mem_ready | input | 1 | Access completes at this clock edge |
| acc_we | output | 1 | Accumulator update, valid with done |
| acc_out | output | 16 | New accumulator value |
| ptr_out | output | 16 | New pointer value, valid with done |
| flag_z | output | 1 | Zero flag value |
| flag_n | output | 1 | Negative flag value |
| flag_c | output | 1 | Carry flag value (always cleared) |

## Verification
A wrong byte counter or direction bit shows up at the very first access: mem_addr is off by one, or the second access goes the wrong way. A stale byte-lane select shows up as a swapped word on acc_out, or a wrong mem_wdata, in the done cycle. A stuck state register shows up as busy failing to drop, or as a missing or doubled done pulse, within one cycle of the last ready. Because the model checks every access against its expected address and data as the access is made, these faults are reported in the cycle where they first reach the port.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

  typedef enum logic [2:0] {
    OP_LDB  = 3'd0,
    OP_STB  = 3'd1,
    OP_LDW  = 3'd2,
    OP_STW  = 3'd3,
    OP_POPB = 3'd4,
    OP_STPB = 3'd5,
    OP_POPW = 3'd6,
    OP_NONE = 3'd7
  } pmu_op_e;

  function automatic logic op_valid(pmu_op_e op);
    return op != OP_NONE;
  endfunction

  function automatic logic op_writes(pmu_op_e op);
    return (op == OP_STB) || (op == OP_STW) || (op == OP_STPB);
  endfunction

  function automatic logic op_word(pmu_op_e op);
    return (op == OP_LDW) || (op == OP_STW) || (op == OP_POPW);
  endfunction

  function automatic logic op_pre_dec(pmu_op_e op);
    return (op == OP_POPB) || (op == OP_STPB) || (op == OP_POPW);
  endfunction

  function automatic logic op_high_first(pmu_op_e op);
    return op == OP_POPW;
  endfunction

endpackage

// File: rtl/pmu_seq.sv
module pmu_seq
  import pmu_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  pmu_op_e           op,
  input  logic [ADDR_W-1:0] ptr_in,
  input  logic              mem_ready,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              beat,
  output pmu_op_e           op_cur,
  output logic              launch,
  output logic              accept,
  output logic              finish,
  output logic [ADDR_W-1:0] ptr_final
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] TWO = ADDR_W'(2);

  function automatic logic [ADDR_W-1:0] move_ptr(logic [ADDR_W-1:0] base,
                                                 logic down,
                                                 logic [ADDR_W-1:0] count);
    return down ? base - count : base + count;
  endfunction

  logic              run_q;
  logic              beat_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] final_q;
  pmu_op_e           op_q;
  logic              last_beat;

  assign launch    = start && !run_q && op_valid(op);
  assign accept    = run_q && mem_ready;
  assign last_beat = !op_word(op_q) || beat_q;
  assign finish    = accept && last_beat;

  assign busy      = run_q;
  assign mem_req   = run_q;
  assign mem_we    = run_q && op_writes(op_q);
  assign mem_addr  = addr_q;
  assign beat      = beat_q;
  assign op_cur    = op_q;
  assign ptr_final = final_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      beat_q  <= 1'b0;
      addr_q  <= '0;
      final_q <= '0;
      op_q    <= OP_NONE;
    end else if (launch) begin
      run_q   <= 1'b1;
      beat_q  <= 1'b0;
      op_q    <= op;
      addr_q  <= op_pre_dec(op) ? ptr_in - ONE : ptr_in;
      final_q <= move_ptr(ptr_in, op_pre_dec(op), op_word(op) ? TWO : ONE);
    end else if (accept) begin
      if (last_beat) begin
        run_q <= 1'b0;
      end else begin
        beat_q <= 1'b1;
        addr_q <= move_ptr(addr_q, op_pre_dec(op_q), ONE);
      end
    end
  end

  assert_addr_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !last_beat) |=>
      (mem_addr == ($past(op_pre_dec(op_q)) ? $past(mem_addr) - ONE : $past(mem_addr) + ONE)));

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

endmodule

// File: rtl/pmu_lane.sv
module pmu_lane
  import pmu_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                launch,
  input  logic [2*BYTE_W-1:0] acc_in,
  input  pmu_op_e             op_cur,
  input  logic                beat,
  input  logic                accept,
  input  logic [BYTE_W-1:0]   mem_rdata,
  output logic [BYTE_W-1:0]   mem_wdata,
  output logic [2*BYTE_W-1:0] xfer_val
);

  localparam int WORD_W = 2 * BYTE_W;

  logic [WORD_W-1:0] acc_q;
  logic [WORD_W-1:0] hold_q;
  logic [WORD_W-1:0] merged;
  logic              lane_hi;

  assign lane_hi   = op_word(op_cur) && (beat ^ op_high_first(op_cur));
  assign mem_wdata = lane_hi ? acc_q[WORD_W-1:BYTE_W] : acc_q[BYTE_W-1:0];

  always_comb begin
    merged = hold_q;
    if (lane_hi) merged[WORD_W-1:BYTE_W] = mem_rdata;
    else         merged[BYTE_W-1:0]      = mem_rdata;
  end

  always_comb begin
    if (op_writes(op_cur))
      xfer_val = op_word(op_cur) ? acc_q : {{BYTE_W{1'b0}}, acc_q[BYTE_W-1:0]};
    else
      xfer_val = merged;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      hold_q <= '0;
    end else if (launch) begin
      acc_q  <= acc_in;
      hold_q <= '0;
    end else if (accept && !op_writes(op_cur)) begin
      hold_q <= merged;
    end
  end

  assert_wdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!launch && !accept) |=> $stable(mem_wdata));

endmodule

// File: rtl/ptr_mem_unit.sv
module ptr_mem_unit
  import pmu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [2:0]          op,
  input  logic [ADDR_W-1:0]   ptr_in,
  input  logic [2*BYTE_W-1:0] acc_in,
  output logic                busy,
  output logic                done,
  output logic                mem_req,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [BYTE_W-1:0]   mem_wdata,
  input  logic [BYTE_W-1:0]   mem_rdata,
  input  logic                mem_ready,
  output logic                acc_we,
  output logic [2*BYTE_W-1:0] acc_out,
  output logic [ADDR_W-1:0]   ptr_out,
  output logic                flag_z,
  output logic                flag_n,
  output logic                flag_c
);

  localparam int WORD_W = 2 * BYTE_W;

  pmu_op_e           op_e;
  pmu_op_e           op_cur;
  logic              beat;
  logic              launch;
  logic              accept;
  logic              finish;
  logic [ADDR_W-1:0] ptr_final;
  logic [WORD_W-1:0] xfer_val;

  assign op_e = pmu_op_e'(op);

  pmu_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .op        (op_e),
    .ptr_in    (ptr_in),
    .mem_ready (mem_ready),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .beat      (beat),
    .op_cur    (op_cur),
    .launch    (launch),
    .accept    (accept),
    .finish    (finish),
    .ptr_final (ptr_final)
  );

  pmu_lane #(.BYTE_W(BYTE_W)) u_lane (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (launch),
    .acc_in    (acc_in),
    .op_cur    (op_cur),
    .beat      (beat),
    .accept    (accept),
    .mem_rdata (mem_rdata),
    .mem_wdata (mem_wdata),
    .xfer_val  (xfer_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done    <= 1'b0;
      acc_we  <= 1'b0;
      acc_out <= '0;
      ptr_out <= '0;
      flag_z  <= 1'b0;
      flag_n  <= 1'b0;
      flag_c  <= 1'b0;
    end else if (finish) begin
      done    <= 1'b1;
      acc_we  <= !op_writes(op_cur);
      ptr_out <= ptr_final;
      flag_z  <= (xfer_val == '0);
      flag_n  <= xfer_val[WORD_W-1];
      flag_c  <= 1'b0;
      if (!op_writes(op_cur)) acc_out <= xfer_val;
    end else begin
      done   <= 1'b0;
      acc_we <= 1'b0;
    end
  end

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_not_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_zero_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && acc_we) |-> (flag_z == (acc_out == '0)));

  assert_bad_code_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && op == 3'd7) |=> !busy);

endmodule

// File: tb/tb_ptr_mem_unit.sv
`timescale 1ns/100ps
module tb_ptr_mem_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [15:0] ptr_in = '0;
  logic [15:0] acc_in = '0;
  logic        busy, done, mem_req, mem_we, acc_we, flag_z, flag_n, flag_c;
  logic [15:0] mem_addr, acc_out, ptr_out;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic        mem_ready = 1'b0;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;
  bit [7:0] mem [int];

  always #2.5 clk = ~clk;

  ptr_mem_unit dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .ptr_in(ptr_in),
    .acc_in(acc_in), .busy(busy), .done(done), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .acc_we(acc_we),
    .acc_out(acc_out), .ptr_out(ptr_out), .flag_z(flag_z),
    .flag_n(flag_n), .flag_c(flag_c)
  );

  function automatic int rd(int a);
    return mem.exists(a) ? int'(mem[a]) : 0;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Reference: codes 0..6 = LDB STB LDW STW POPB STPB POPW
  task automatic run_op(int code, int ptr, int acc, int waits, bit poke, string req);
    int  nb = (code == 2 || code == 3 || code == 6) ? 2 : 1;
    bit  down = (code >= 4);
    bit  wr = (code == 1 || code == 3 || code == 5);
    int  addr [2];
    int  wd [2];
    int  val;
    int  endp;
    for (int i = 0; i < nb; i++) addr[i] = down ? ((ptr - 1 - i) & 16'hFFFF) : ((ptr + i) & 16'hFFFF);
    wd[0] = acc & 8'hFF;
    wd[1] = (acc >> 8) & 8'hFF;
    case (code)
      0, 4: val = rd(addr[0]);
      2:    val = rd(addr[0]) | (rd(addr[1]) << 8);
      6:    val = (rd(addr[0]) << 8) | rd(addr[1]);
      3:    val = acc & 16'hFFFF;
      default: val = acc & 8'hFF;
    endcase
    endp = down ? ((ptr - nb) & 16'hFFFF) : ((ptr + nb) & 16'hFFFF);

    @(negedge clk);
    start = 1'b1; op = 3'(code); ptr_in = 16'(ptr); acc_in = 16'(acc);
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R11", "busy after launch", busy, 1);
    for (int i = 0; i < nb; i++) begin
      for (int w = waits; w >= 0; w--) begin
        string tag = (w == waits) ? req : "R12";
        chk(mem_req == 1'b1, tag, "mem_req", mem_req, 1);
        chk(mem_addr == 16'(addr[i]), tag, "mem_addr", mem_addr, addr[i]);
        chk(mem_we == wr, tag, "mem_we", mem_we, wr);
        if (wr) chk(mem_wdata == 8'(wd[(code == 3) ? i : 0]), tag, "mem_wdata",
                    mem_wdata, wd[(code == 3) ? i : 0]);
        if (w > 0) begin
          mem_ready = 1'b0;
          if (poke && w == waits) begin
            start = 1'b1; op = 3'd0; ptr_in = 16'h0FF0;
          end else start = 1'b0;
        end else begin
          start = 1'b0;
          mem_ready = 1'b1;
          mem_rdata = 8'(rd(addr[i]));
          if (wr) mem[addr[i]] = 8'(wd[(code == 3) ? i : 0]);
        end
        @(negedge clk);
        mem_ready = 1'b0;
      end
    end
    chk(done == 1'b1, "R11", "done", done, 1);
    chk(busy == 1'b0, "R11", "busy at done", busy, 0);
    chk(ptr_out == 16'(endp), "R10", "ptr_out", ptr_out, endp);
    chk(acc_we == !wr, req, "acc_we", acc_we, !wr);
    if (!wr) chk(acc_out == 16'(val), req, "acc_out", acc_out, val);
    chk(flag_z == (val == 0), "R9", "flag_z", flag_z, val == 0);
    chk(flag_n == val[15], "R9", "flag_n", flag_n, val[15]);
    chk(flag_c == 1'b0, "R9", "flag_c", flag_c, 0);
    @(negedge clk);
    chk(done == 1'b0, "R11", "done pulse width", done, 0);
    chk(busy == 1'b0, "R13", "no relaunch", busy, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    mem[16'h0100] = 8'h85;
    mem[16'h0300] = 8'h34;
    mem[16'h0301] = 8'h92;
    mem[16'hFFFF] = 8'h00;
    mem[16'h0000] = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 0 && done == 0 && mem_req == 0, "R1", "control outputs", {busy, done, mem_req}, 0);
    chk(acc_we == 0 && acc_out == 0 && ptr_out == 0, "R1", "result outputs", acc_out, 0);
    chk({flag_z, flag_n, flag_c} == 3'b000, "R1", "flags", {flag_z, flag_n, flag_c}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_op(0, 16'h0100, 16'h7777, 0, 0, "R2");
    run_op(1, 16'h0200, 16'hABCD, 2, 1, "R3");
    run_op(2, 16'h0300, 16'h0000, 1, 0, "R4");
    run_op(3, 16'h0400, 16'h8001, 1, 0, "R5");
    run_op(4, 16'h0201, 16'h5555, 0, 0, "R6");
    run_op(5, 16'h0500, 16'h1200, 0, 0, "R7");
    run_op(6, 16'h0402, 16'h0000, 2, 0, "R8");
    run_op(2, 16'hFFFF, 16'h0000, 0, 0, "R10");
    run_op(4, 16'h0000, 16'h0000, 1, 0, "R10");
    run_op(6, 16'h0001, 16'h0000, 0, 0, "R10");
    run_op(5, 16'h0000, 16'h00C3, 0, 1, "R10");
    // R13 code 7 ignored
    start = 1'b1; op = 3'd7; ptr_in = 16'h1234;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk(busy == 0 && mem_req == 0 && done == 0, "R13", "code 7 inert",
          {busy, mem_req, done}, 0);
      @(negedge clk);
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule